// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It has its own test clock, a mode-select line and a serial data line. A sixteen-state controller follows the mode-select line and steps through the standard capture, shift and update phases. These phases act either on a three-bit instruction register or on a data register. The data register is a one-bit bypass stage or a boundary chain of pin cells, and the instruction in force picks which one. There is no asynchronous test-reset pin. The controller returns to Test-Logic-Reset only through the chip's power-on reset or by holding mode-select high.

The block sits between the core and the pads. For each output pad it passes the core's value and enable through, or replaces them as the instruction requires. For each input pad it samples the pin value into the chain. Serial output changes on the falling test-clock edge. It is enabled only while a register is being shifted, so several devices can share a daisy chain.

States: Test-Logic-Reset (TLR), Run-Test/Idle (RTI), Select-DR (SEL_DR), Capture-DR (CAP_DR), Shift-DR (SH_DR), Exit1-DR (EX1_DR), Pause-DR (PAU_DR), Exit2-DR (EX2_DR), Update-DR (UPD_DR), and the matching Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR (SEL_IR … UPD_IR). On a rising edge with mode-select (ms) low, the controller moves as follows:
- TLR→RTI, RTI→RTI, SEL_DR→CAP_DR, SEL_IR→CAP_IR.
- CAP_x→SH_x, SH_x→SH_x, EX1_x→PAU_x, PAU_x→PAU_x, EX2_x→SH_x.
- UPD_x→RTI.

With ms high, it moves as follows:
- TLR→TLR, RTI→SEL_DR, SEL_DR→SEL_IR, SEL_IR→TLR.
- CAP_x→EX1_x, SH_x→EX1_x, EX1_x→UPD_x, PAU_x→EX2_x, EX2_x→UPD_x.
- UPD_x→SEL_DR.

Top module: `scan_tap_ctrl`

## Requirements
- R1: A low on `por_n` puts the controller in TLR at once. It also sets the active instruction to 111, clears the boundary update latch and turns `tdo_oe` off.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to TLR from any state. On the falling edge in TLR the active instruction becomes 111.
- R3: The controller samples `tms` and `tdi` on the rising `tck` edge and follows the state graph given above. For example, four highs from Shift-DR land in Select-IR and do not reset the controller.
- R4: The instruction register is 3 bits wide and shifts with bit 0 nearest `tdo`. Capture-IR loads 001. The active instruction takes the shifted value on the falling edge in Update-IR.
- R5: The instruction codes are 000 drive-from-chain, 001 sample/preload, 101 pins-off, 110 hold-pins and 111 bypass. The codes 010, 011 and 100 act as bypass.
- R6: Under bypass, the one-bit stage loads 0 in Capture-DR and delays `tdi` by one `tck` in Shift-DR.
- R7: Under 000, each `pad_out[i]` equals latch bit NIN+i and `pad_oe` is 1. `drive_bsr` is 1. The chain captures the pins.
- R8: Under 001, the pads carry `core_out`/`core_oe`. Capture-DR loads `{core_out, pin_in}`. Shifting and updating do not change the pads.
- R9: Under 101, `pad_oe` is 0, `pins_off` is 1, and the one-bit stage is the data register.
- R10: Under 110, the pads carry the latch's output cells with `pad_oe` 1, and the one-bit stage is the data register.
- R11: `tdo` and `tdo_oe` change on the falling `tck` edge. `tdo_oe` is 1 only in Shift-DR and Shift-IR.
- R12: The chain holds input cells in bits 0 to NIN-1 and output cells above them, with bit 0 shifted out first. Under 000 or 001, the latch copies the chain on the falling edge in Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Enable for the tdo driver |
| pin_in | input | NIN | Values at the input pads |
| core_out | input | NOUT | Core's functional output values |
| core_oe | input | 1 | Core's output enable |
| pad_out | output | NOUT | Values sent to the output pads |
| pad_oe | output | 1 | Output pad driver enable |
| drive_bsr | output | 1 | Pads are driven from the update latch |
| pins_off | output | 1 | All output drivers are forced off |

## Verification
The situation that is hardest to reach is a reset that comes from `tms` alone while the controller is deep in a data scan with a chain-driving instruction in force. The stimulus first loads 000 and enters Shift-DR. It then raises `tms` for four edges and confirms the controller has only reached Select-IR. A fifth high edge must drop the drive select. Every instruction code, including the three unassigned ones, is also walked through a table. The first captured bit tells the one-bit stage apart from the chain.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_DRIVE  = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
    localparam logic [IR_W-1:0] OP_OFF    = 3'b101;
    localparam logic [IR_W-1:0] OP_HOLD   = 3'b110;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PATTERN = 3'b001;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic sel_bsr;    // chain is the data register
        logic drive_bsr;  // pads take the update latch
        logic pins_off;   // output drivers disabled
    } op_ctl_t;

    function automatic op_ctl_t decode_op(logic [IR_W-1:0] op);
        op_ctl_t c;
        c = '0;
        unique case (op)
            OP_DRIVE:  begin c.sel_bsr = 1'b1; c.drive_bsr = 1'b1; end
            OP_SAMPLE: c.sel_bsr = 1'b1;
            OP_OFF:    c.pins_off = 1'b1;
            OP_HOLD:   c.drive_bsr = 1'b1;
            default:   c = '0; // 111 and unassigned codes: bypass
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_tlr,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            TLR:    nxt = tms ? TLR    : RTI;
            RTI:    nxt = tms ? SEL_DR : RTI;
            SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR: nxt = tms ? EX1_DR : SH_DR;
            SH_DR:  nxt = tms ? EX1_DR : SH_DR;
            EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR: nxt = tms ? UPD_DR : SH_DR;
            UPD_DR: nxt = tms ? SEL_DR : RTI;
            SEL_IR: nxt = tms ? TLR    : CAP_IR;
            CAP_IR: nxt = tms ? EX1_IR : SH_IR;
            SH_IR:  nxt = tms ? EX1_IR : SH_IR;
            EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR: nxt = tms ? UPD_IR : SH_IR;
            UPD_IR: nxt = tms ? SEL_DR : RTI;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= TLR;
        else        state <= nxt;
    end

    always_comb begin
        in_tlr = (state == TLR);
        cap_dr = (state == CAP_DR);
        sh_dr  = (state == SH_DR);
        upd_dr = (state == UPD_DR);
        cap_ir = (state == CAP_IR);
        sh_ir  = (state == SH_IR);
        upd_ir = (state == UPD_IR);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  logic            in_tlr,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_op
);

    logic [IR_W-1:0] shreg;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      shreg <= IR_CAPTURE_PATTERN;
        else if (cap_ir) shreg <= IR_CAPTURE_PATTERN;
        else if (sh_ir)  shreg <= {tdi, shreg[IR_W-1:1]};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n)      ir_op <= OP_BYPASS;
        else if (in_tlr) ir_op <= OP_BYPASS;
        else if (upd_ir) ir_op <= shreg;
    end

    assign ir_so = shreg[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
    parameter int NIN  = 4,
    parameter int NOUT = 4
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tdi,
    input  logic             sel,
    input  logic             cap_dr,
    input  logic             sh_dr,
    input  logic             upd_dr,
    input  logic [NIN-1:0]   pin_in,
    input  logic [NOUT-1:0]  core_out,
    output logic             bsr_so,
    output logic [NOUT-1:0]  hold_out
);

    localparam int LEN = NIN + NOUT;

    logic [LEN-1:0] chain;
    logic [LEN-1:0] latch;
    logic [LEN-1:0] cap_val;
    logic [LEN-1:0] shift_src;

    assign cap_val = {core_out, pin_in};

    genvar i;
    generate
        for (i = 0; i < LEN; i++) begin : g_cell
            if (i == LEN - 1) begin : g_last
                assign shift_src[i] = tdi;
            end else begin : g_mid
                assign shift_src[i] = chain[i+1];
            end

            always_ff @(posedge tck or negedge por_n) begin
                if (!por_n)                chain[i] <= 1'b0;
                else if (sel && cap_dr)    chain[i] <= cap_val[i];
                else if (sel && sh_dr)     chain[i] <= shift_src[i];
            end

            always_ff @(negedge tck or negedge por_n) begin
                if (!por_n)                latch[i] <= 1'b0;
                else if (sel && upd_dr)    latch[i] <= chain[i];
            end
        end
    endgenerate

    assign bsr_so   = chain[0];
    assign hold_out = latch[LEN-1:NIN];

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int NIN  = 4,
    parameter int NOUT = 4
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [NIN-1:0]  pin_in,
    input  logic [NOUT-1:0] core_out,
    input  logic            core_oe,
    output logic [NOUT-1:0] pad_out,
    output logic            pad_oe,
    output logic            drive_bsr,
    output logic            pins_off
);

    tap_state_e      state;
    logic            in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic            ir_so, bsr_so, byp;
    logic [IR_W-1:0] ir_op;
    logic [NOUT-1:0] hold_out;
    op_ctl_t         ctl;
    logic            sel_bsr;

    tap_fsm u_fsm (
        .tck(tck), .por_n(por_n), .tms(tms), .state(state),
        .in_tlr(in_tlr), .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
    );

    tap_ir u_ir (
        .tck(tck), .por_n(por_n), .tdi(tdi), .in_tlr(in_tlr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .ir_so(ir_so), .ir_op(ir_op)
    );

    assign ctl       = decode_op(ir_op);
    assign sel_bsr   = ctl.sel_bsr;
    assign drive_bsr = ctl.drive_bsr;
    assign pins_off  = ctl.pins_off;

    tap_bsr #(.NIN(NIN), .NOUT(NOUT)) u_bsr (
        .tck(tck), .por_n(por_n), .tdi(tdi), .sel(sel_bsr),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .pin_in(pin_in), .core_out(core_out),
        .bsr_so(bsr_so), .hold_out(hold_out)
    );

    // one-bit bypass stage
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      byp <= 1'b0;
        else if (cap_dr) byp <= 1'b0;
        else if (sh_dr)  byp <= tdi;
    end

    // serial output retimed to the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= sh_dr | sh_ir;
            tdo    <= sh_ir ? ir_so : (sel_bsr ? bsr_so : byp);
        end
    end

    genvar k;
    generate
        for (k = 0; k < NOUT; k++) begin : g_pad
            assign pad_out[k] = drive_bsr ? hold_out[k] : core_out[k];
        end
    endgenerate

    assign pad_oe = pins_off ? 1'b0 : (drive_bsr ? 1'b1 : core_oe);

endmodule

// File: rtl/scan_tap_checker.sv
module scan_tap_checker
    import scan_tap_pkg::*;
(
    input logic            tck,
    input logic            por_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_op,
    input logic            tdo_oe,
    input logic            pad_oe,
    input logic            drive_bsr,
    input logic            pins_off
);

    logic [2:0] ms_run;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)           ms_run <= '0;
        else if (!tms)        ms_run <= '0;
        else if (ms_run != 3'd7) ms_run <= ms_run + 3'd1;
    end

    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
        (tms && ms_run >= 3'd4) |=> (state == TLR));

    a_r1_tlr_bypass_op: assert property (@(posedge tck) disable iff (!por_n)
        (state == TLR && $past(state) == TLR) |-> (ir_op == OP_BYPASS));

    a_r11_tdo_only_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == SH_DR || state == SH_IR));

    a_r9_off_disables: assert property (@(posedge tck) disable iff (!por_n)
        pins_off |-> !pad_oe);

    a_r10_drive_enables: assert property (@(posedge tck) disable iff (!por_n)
        drive_bsr |-> pad_oe);

    a_r5_modes_exclusive: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({drive_bsr, pins_off}));

    a_r5_unassigned_bypass: assert property (@(posedge tck) disable iff (!por_n)
        (ir_op == 3'b010 || ir_op == 3'b011 || ir_op == 3'b100)
        |-> (!drive_bsr && !pins_off));

endmodule

bind scan_tap_ctrl scan_tap_checker u_chk (
    .tck(tck), .por_n(por_n), .tms(tms), .state(state), .ir_op(ir_op),
    .tdo_oe(tdo_oe), .pad_oe(pad_oe), .drive_bsr(drive_bsr), .pins_off(pins_off)
);

// File: tb/scan_tap_ctrl_test.sv
module scan_tap_ctrl_test;

    localparam int NIN  = 4;
    localparam int NOUT = 4;
    localparam int LEN  = NIN + NOUT;

    logic            tck = 1'b0;
    logic            por_n = 1'b0;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic            tdo, tdo_oe;
    logic [NIN-1:0]  pin_in = '0;
    logic [NOUT-1:0] core_out = '0;
    logic            core_oe = 1'b0;
    logic [NOUT-1:0] pad_out;
    logic            pad_oe, drive_bsr, pins_off;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 tck = ~tck;

    scan_tap_ctrl #(.NIN(NIN), .NOUT(NOUT)) uut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .pin_in(pin_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .drive_bsr(drive_bsr), .pins_off(pins_off)
    );

    // {code[2:0], drive_bsr, pins_off, first captured tdo} with core_oe=0, pin_in=0001
    localparam logic [5:0] VEC [0:7] = '{
        6'b000_1_0_1, 6'b001_0_0_1, 6'b010_0_0_0, 6'b011_0_0_0,
        6'b100_0_0_0, 6'b101_0_1_0, 6'b110_1_0_0, 6'b111_0_0_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            seen[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input logic [15:0] din, input int n, output logic [15:0] dout);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0]  irs;
        logic [15:0] dout;

        core_out = 4'hA;
        core_oe  = 1'b1;
        repeat (3) @(negedge tck);
        #1;
        // R1: reset state
        check("R1 tdo_oe", tdo_oe, 0);
        check("R1 drive_bsr", drive_bsr, 0);
        check("R1 pins_off", pins_off, 0);
        check("R1 pad_out", pad_out, 4'hA);
        check("R1 pad_oe", pad_oe, 1);
        por_n = 1'b1;
        @(negedge tck);
        #1;
        to_idle();

        // R5 table of every instruction code
        core_oe = 1'b0;
        pin_in  = 4'h1;
        for (int k = 0; k < 8; k++) begin
            load_ir(VEC[k][5:3], irs);
            check("R5 drive_bsr", drive_bsr, VEC[k][2]);
            check("R5 pins_off", pins_off, VEC[k][1]);
            check("R5 pad_oe", pad_oe, VEC[k][2]);
            scan_dr(16'h0, 1, dout);
            check("R5 first captured tdo", dout[0], VEC[k][0]);
        end

        // R4: capture pattern 001 shifted LSB first
        load_ir(3'b001, irs);
        check("R4 capture pattern", irs, 3'b001);

        // R8: sample/preload
        pin_in = 4'h5;
        scan_dr(16'h003C, LEN, dout);
        check("R8 snapshot", dout[LEN-1:0], 8'hA5);
        check("R8 pads untouched", pad_out, 4'hA);

        // R7 / R12: drive from chain
        load_ir(3'b000, irs);
        check("R7 pad_out from latch", pad_out, 4'h3);
        check("R7 pad_oe", pad_oe, 1);
        pin_in = 4'h9;
        scan_dr(16'h006C, LEN, dout);
        check("R7 pins captured", dout[NIN-1:0], 4'h9);
        check("R12 latch update", pad_out, 4'h6);
        // R11: tdo disabled outside shift
        check("R11 tdo_oe idle", tdo_oe, 0);

        // R6: bypass delay
        load_ir(3'b111, irs);
        check("R6 pads follow core", pad_out, 4'hA);
        scan_dr(16'h0016, 5, dout);
        check("R6 one-cycle delay", dout[4:0], 5'h0C);

        // R10: hold pins from latch, bypass selected
        load_ir(3'b110, irs);
        check("R10 pad_out", pad_out, 4'h6);
        check("R10 pad_oe", pad_oe, 1);
        scan_dr(16'h0003, 3, dout);
        check("R10 bypass path", dout[2:0], 3'b110);

        // R9: all drivers off
        core_oe = 1'b1;
        load_ir(3'b101, irs);
        check("R9 pad_oe", pad_oe, 0);
        check("R9 pins_off", pins_off, 1);

        // R3 / R2: reset from TMS while in Shift-DR
        load_ir(3'b000, irs);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R11 tdo_oe in shift", tdo_oe, 1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        check("R3 four highs keep op", drive_bsr, 1);
        step(1'b1, 1'b0);
        check("R2 fifth high resets op", drive_bsr, 0);
        check("R2 pad_out from core", pad_out, 4'hA);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule